// File: doc/BRIEF.md
# Cascadable Reload Timer Trio with Toggle Output

This block holds three down-counters, each with its own reload latch. All three share one mode register. The first timer counts one of two external clock-enable ticks and can be halted. The second and third timers either count the underflow of the first, which chains them into longer periods, or count a clock-enable tick of their own. Every underflow reloads the counter from its latch and raises that timer's interrupt flag. Software clears a flag by writing a one to it.

A square-wave output follows the underflows of the first or second timer. The output has a programmable starting level and an enable. While the output is disabled, the pin sits at a fixed idle level.

Software reaches the block through one register port with a two-bit address:

| Address | Register |
|---|---|
| 0 | Mode register |
| 1 | First timer |
| 2 | Second timer |
| 3 | Third timer |

Reading a timer address returns the live count value. Reading address 0 returns the mode register.

Top module: `cascade_timer_trio`

## Requirements
- R1: After reset the mode register reads 0x00, every counter reads all ones, every interrupt flag is 0, and both `tout` and `tout_oe` are 0.
- R2: Each counter moves down by one on each of its count ticks. A tick that arrives while the counter holds zero is an underflow: it reloads the counter from the latch and sets the timer's flag in `irq_flag` (bit 0 is the first timer) one cycle later.
- R3: With mode bit 7 at 0, a write to the first or second timer stores the data in both the counter and the latch. A write to the third timer always does this, whatever bit 7 holds.
- R4: With mode bit 7 at 1, a write to the first or second timer updates only the latch. The counter keeps its value and takes the new data at its next underflow.
- R5: Mode bit 1 at 1 halts the first timer, so its count ticks have no effect. At 0 the first timer runs.
- R6: Mode bit 2 picks the count source of the first timer: `tick_div8` when 0, `tick_sub2` when 1.
- R7: Mode bit 3 picks the count source of the second timer: the first timer's underflow when 0, `tick_sys` when 1.
- R8: Mode bit 4 picks the count source of the third timer: the first timer's underflow when 0, `tick_div8` when 1.
- R9: While enabled, `tout` inverts on every underflow of the source timer. Mode bit 0 selects the source: 0 for the first timer, 1 for the second. Underflows of the other timer leave `tout` alone.
- R10: Mode bit 6 enables the output. While it is 0, `tout` and `tout_oe` are 0. Mode bit 5 sets the starting level: high when 0, low when 1. Any mode write that raises bit 6 or changes bit 5 restarts `tout` at the starting level.
- R11: A 1 on bit n of `irq_clr` clears flag n in the next cycle. An underflow in that same cycle wins, and the flag stays set.
- R12: A write that loads a counter directly takes priority over a count tick in the same cycle. The written value is kept, and that tick causes no underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 mode, 1..3 timers |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for the selected register |
| tick_div8 | input | 1 | System clock divided by 8, one-cycle enable |
| tick_sys | input | 1 | Undivided system clock enable |
| tick_sub2 | input | 1 | Sub-clock divided by 2, one-cycle enable |
| irq_clr | input | 3 | Write-one-to-clear strobes for the flags |
| irq_flag | output | 3 | Interrupt request flags, bit 0 is the first timer |
| tout | output | 1 | Square-wave output |
| tout_oe | output | 1 | Output enable for the square-wave pin |

## Verification
The bench loads a new value while the latch-only control is set. A design that ignored the control would show the new value at once instead of the old count.

It fires a count tick on the same cycle as a direct write to a counter sitting at zero. A design with the wrong priority would reload from the latch or raise a stray flag.

It sends a clear strobe together with an underflow. A clear-first design would drop the request.

It switches the output's source timer and its polarity. A design that kept toggling on the unselected timer, or that did not restart the output level on a polarity change or on re-enable, would show the wrong level on `tout`.

// File: rtl/ctt_pkg.sv
package ctt_pkg;

   // register select on the two-bit bus address
   typedef enum logic [1:0] {
      SEL_MODE = 2'd0,
      SEL_T1   = 2'd1,
      SEL_T2   = 2'd2,
      SEL_T3   = 2'd3
   } reg_sel_e;

   // mode register, MSB first; bit positions are software visible
   typedef struct packed {
      logic latch_only;    // bit 7
      logic out_en;        // bit 6
      logic out_start_low; // bit 5
      logic t3_own_clk;    // bit 4
      logic t2_own_clk;    // bit 3
      logic t1_sub_clk;    // bit 2
      logic t1_halt;       // bit 1
      logic out_from_t2;   // bit 0
   } mode_t;

   localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/ctt_counter.sv
module ctt_counter #(
   parameter int           DW        = 8,
   parameter logic [DW-1:0] RST_COUNT = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          wr,
   input  logic          latch_only,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] cnt,
   output logic          uf
);

   logic [DW-1:0] latch_q;
   logic          wr_direct;
   logic          at_zero;
   logic [DW-1:0] reload_val;

   assign wr_direct  = wr & ~latch_only;
   assign at_zero    = (cnt == '0);
   assign uf         = tick & at_zero & ~wr_direct;
   // a latch-only write in the underflow cycle is taken at once
   assign reload_val = (wr & latch_only) ? wdata : latch_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= RST_COUNT;
         cnt     <= RST_COUNT;
      end else begin
         if (wr) begin
            latch_q <= wdata;
         end
         if (wr_direct) begin
            cnt <= wdata;
         end else if (tick) begin
            cnt <= at_zero ? reload_val : cnt - 1'b1;
         end
      end
   end

   assert_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

   assert_direct_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !latch_only) |=> cnt == $past(wdata));

   assert_latch_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && latch_only && !tick) |=> $stable(cnt));

   assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !latch_only && tick) |-> !uf);

endmodule

// File: rtl/ctt_toggle.sv
module ctt_toggle #(
   parameter logic RST_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic init,
   input  logic init_level,
   input  logic tgl,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST_LEVEL;
      end else if (init) begin
         q <= init_level;
      end else if (tgl) begin
         q <= ~q;
      end
   end

   assert_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (tgl && !init) |=> q != $past(q));

   assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> q == $past(init_level));

endmodule

// File: rtl/cascade_timer_trio.sv
module cascade_timer_trio
   import ctt_pkg::*;
#(
   parameter int   DW                = 8,
   parameter logic IDLE_LEVEL        = 1'b0,
   parameter bit   T3_SHARES_WR_CTRL = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [1:0]    bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   input  logic          tick_div8,
   input  logic          tick_sys,
   input  logic          tick_sub2,
   input  logic [2:0]    irq_clr,
   output logic [2:0]    irq_flag,
   output logic          tout,
   output logic          tout_oe
);

   localparam logic [DW-1:0] CNT_RST = '1;

   generate
      if (DW < MODE_W) begin : g_bad_width
         $error("cascade_timer_trio: DW must be at least the mode width");
      end
   endgenerate

   mode_t         mode_q;
   mode_t         mode_new;
   logic          wr_mode, wr_t1, wr_t2, wr_t3;
   logic          t1_tick, t2_tick, t3_tick;
   logic          uf1, uf2, uf3;
   logic [DW-1:0] cnt1, cnt2, cnt3;
   logic          t3_latch_only;
   logic          out_init, out_tgl, out_q;

   assign wr_mode  = bus_we && (bus_addr == SEL_MODE);
   assign wr_t1    = bus_we && (bus_addr == SEL_T1);
   assign wr_t2    = bus_we && (bus_addr == SEL_T2);
   assign wr_t3    = bus_we && (bus_addr == SEL_T3);
   assign mode_new = mode_t'(bus_wdata[MODE_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (wr_mode) begin
         mode_q <= mode_new;
      end
   end

   // count source selection
   assign t1_tick = ~mode_q.t1_halt & (mode_q.t1_sub_clk ? tick_sub2 : tick_div8);
   assign t2_tick = mode_q.t2_own_clk ? tick_sys  : uf1;
   assign t3_tick = mode_q.t3_own_clk ? tick_div8 : uf1;

   generate
      if (T3_SHARES_WR_CTRL) begin : g_t3_shared
         assign t3_latch_only = mode_q.latch_only;
      end else begin : g_t3_direct
         assign t3_latch_only = 1'b0;
      end
   endgenerate

   ctt_counter #(.DW(DW), .RST_COUNT(CNT_RST)) u_t1 (
      .clk(clk), .rst_n(rst_n), .tick(t1_tick), .wr(wr_t1),
      .latch_only(mode_q.latch_only), .wdata(bus_wdata), .cnt(cnt1), .uf(uf1));

   ctt_counter #(.DW(DW), .RST_COUNT(CNT_RST)) u_t2 (
      .clk(clk), .rst_n(rst_n), .tick(t2_tick), .wr(wr_t2),
      .latch_only(mode_q.latch_only), .wdata(bus_wdata), .cnt(cnt2), .uf(uf2));

   ctt_counter #(.DW(DW), .RST_COUNT(CNT_RST)) u_t3 (
      .clk(clk), .rst_n(rst_n), .tick(t3_tick), .wr(wr_t3),
      .latch_only(t3_latch_only), .wdata(bus_wdata), .cnt(cnt3), .uf(uf3));

   // interrupt flags: underflow sets, strobe clears, set wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_flag <= '0;
      end else begin
         irq_flag[0] <= uf1 | (irq_flag[0] & ~irq_clr[0]);
         irq_flag[1] <= uf2 | (irq_flag[1] & ~irq_clr[1]);
         irq_flag[2] <= uf3 | (irq_flag[2] & ~irq_clr[2]);
      end
   end

   // square-wave output
   assign out_init = wr_mode &&
                     ((mode_new.out_en && !mode_q.out_en) ||
                      (mode_new.out_start_low != mode_q.out_start_low));
   assign out_tgl  = mode_q.out_en & (mode_q.out_from_t2 ? uf2 : uf1);

   ctt_toggle #(.RST_LEVEL(1'b1)) u_tout (
      .clk(clk), .rst_n(rst_n), .init(out_init),
      .init_level(~mode_new.out_start_low), .tgl(out_tgl), .q(out_q));

   assign tout    = mode_q.out_en ? out_q : IDLE_LEVEL;
   assign tout_oe = mode_q.out_en;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         SEL_MODE: bus_rdata[MODE_W-1:0] = mode_q;
         SEL_T1:   bus_rdata = cnt1;
         SEL_T2:   bus_rdata = cnt2;
         default:  bus_rdata = cnt3;
      endcase
   end

   assert_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q.t1_halt && !wr_t1) |=> $stable(cnt1));

   assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr[0] && !uf1 && irq_flag[0]) |=> !irq_flag[0]);

   assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      uf1 |=> irq_flag[0]);

   assert_pin_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q.out_en |-> (tout == IDLE_LEVEL && !tout_oe));

endmodule

// File: tb/cascade_timer_trio_tb.sv
`timescale 1ns/1ps
module cascade_timer_trio_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_we = 1'b0;
   logic [1:0] bus_addr = 2'd0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       tick_div8 = 1'b0, tick_sys = 1'b0, tick_sub2 = 1'b0;
   logic [2:0] irq_clr = 3'd0;
   logic [2:0] irq_flag;
   logic       tout, tout_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   cascade_timer_trio u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_div8(tick_div8),
      .tick_sys(tick_sys), .tick_sub2(tick_sub2), .irq_clr(irq_clr),
      .irq_flag(irq_flag), .tout(tout), .tout_oe(tout_oe));

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output int v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   // which: 0 div8, 1 sys, 2 sub2
   task automatic pulse(input int which);
      @(negedge clk);
      tick_div8 = (which == 0); tick_sys = (which == 1); tick_sub2 = (which == 2);
      @(negedge clk);
      tick_div8 = 1'b0; tick_sys = 1'b0; tick_sub2 = 1'b0;
   endtask

   task automatic clear_all();
      @(negedge clk);
      irq_clr = 3'b111;
      @(negedge clk);
      irq_clr = 3'b000;
   endtask

   task automatic t_reset();
      int v;
      rd(2'd0, v); chk("R1 mode", v, 0);
      rd(2'd1, v); chk("R1 t1", v, 255);
      rd(2'd3, v); chk("R1 t3", v, 255);
      chk("R1 irq", irq_flag, 0);
      chk("R1 tout", tout, 0);
      chk("R1 oe", tout_oe, 0);
   endtask

   task automatic t_countdown();
      int v;
      wr(2'd0, 8'h00);
      wr(2'd1, 8'd3);
      rd(2'd1, v); chk("R3 t1 direct", v, 3);
      wr(2'd2, 8'd10);
      wr(2'd3, 8'd20);
      repeat (3) pulse(0);
      rd(2'd1, v); chk("R2 down to zero", v, 0);
      chk("R2 no flag yet", irq_flag[0], 0);
      pulse(0);
      rd(2'd1, v); chk("R2 reload", v, 3);
      chk("R2 flag", irq_flag[0], 1);
      rd(2'd2, v); chk("R7 cascade t2", v, 9);
      rd(2'd3, v); chk("R8 cascade t3", v, 19);
      pulse(1);
      rd(2'd2, v); chk("R7 sys ignored", v, 9);
      pulse(2);
      rd(2'd1, v); chk("R6 sub2 ignored", v, 3);
   endtask

   task automatic t_irq();
      clear_all();
      chk("R11 cleared", irq_flag[0], 0);
      repeat (3) pulse(0);
      @(negedge clk);
      tick_div8 = 1'b1; irq_clr = 3'b001;
      @(negedge clk);
      tick_div8 = 1'b0; irq_clr = 3'b000;
      chk("R11 set wins", irq_flag[0], 1);
      clear_all();
   endtask

   task automatic t_sources();
      int v1, v2, v3, v;
      wr(2'd0, 8'h1C);
      rd(2'd1, v1); rd(2'd2, v2); rd(2'd3, v3);
      pulse(0);
      rd(2'd1, v); chk("R6 div8 ignored", v, v1);
      rd(2'd3, v); chk("R8 div8 source", v, v3 - 1);
      pulse(2);
      rd(2'd1, v); chk("R6 sub2 source", v, v1 - 1);
      pulse(1);
      rd(2'd2, v); chk("R7 sys source", v, v2 - 1);
   endtask

   task automatic t_halt();
      int v;
      wr(2'd0, 8'h00);
      wr(2'd1, 8'd50);
      wr(2'd0, 8'h02);
      pulse(0);
      rd(2'd1, v); chk("R5 halted", v, 50);
      wr(2'd0, 8'h00);
      pulse(0);
      rd(2'd1, v); chk("R5 running", v, 49);
   endtask

   task automatic t_latch_only();
      int v;
      wr(2'd1, 8'd1);
      wr(2'd2, 8'd40);
      wr(2'd0, 8'h88);
      wr(2'd1, 8'd5);
      rd(2'd1, v); chk("R4 t1 unchanged", v, 1);
      wr(2'd2, 8'd70);
      rd(2'd2, v); chk("R4 t2 unchanged", v, 40);
      wr(2'd3, 8'd9);
      rd(2'd3, v); chk("R3 t3 always direct", v, 9);
      pulse(0);
      pulse(0);
      rd(2'd1, v); chk("R4 new value at underflow", v, 5);
      clear_all();
   endtask

   task automatic t_collision();
      int v;
      wr(2'd0, 8'h00);
      wr(2'd1, 8'd0);
      clear_all();
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 8'd7; tick_div8 = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; tick_div8 = 1'b0;
      rd(2'd1, v); chk("R12 write kept", v, 7);
      chk("R12 no underflow", irq_flag[0], 0);
   endtask

   task automatic t_tout();
      wr(2'd1, 8'd0);
      wr(2'd0, 8'h40);
      chk("R10 start high", tout, 1);
      chk("R10 oe", tout_oe, 1);
      pulse(0);
      chk("R9 toggle low", tout, 0);
      pulse(0);
      chk("R9 toggle high", tout, 1);
      wr(2'd0, 8'h60);
      chk("R10 polarity restart", tout, 0);
      pulse(0);
      chk("R9 toggle", tout, 1);
      wr(2'd0, 8'h69);
      chk("R10 no restart", tout, 1);
      wr(2'd2, 8'd0);
      pulse(1);
      chk("R9 t2 source", tout, 0);
      pulse(0);
      chk("R9 t1 ignored", tout, 0);
      wr(2'd0, 8'h29);
      chk("R10 disabled pin", tout, 0);
      chk("R10 disabled oe", tout_oe, 0);
      wr(2'd0, 8'h49);
      chk("R10 enable restart", tout, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: got 0 expected 1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_countdown();
      t_irq();
      t_sources();
      t_halt();
      t_latch_only();
      t_collision();
      t_tout();
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule